// File: doc/BRIEF.md
# Configurable Two-Input Cell Array

This block is a small reconfigurable logic fabric. Two primary inputs feed a shared node space. Four programmable cells, grouped as two blocks of two, each read two nodes through routing selectors. Each cell applies one gate function chosen from a fixed menu. Two output selectors then pick which nodes drive the two fabric outputs. A 42-bit configuration word is captured into a register through a valid/ready load port. From that register the fabric is purely combinational, from `pin` to `pout`.

The load port never applies back-pressure: `cfg_ready` is held high, so every cycle with `cfg_valid` high loads a word. A new configuration governs the outputs from the cycle after the load edge. Routing is forward-only. A cell can see only the primary inputs and the outputs of cells with a lower index, so no configuration can close a combinational loop.

Top module: `fab_array`

## Requirements
- R1: While `rst_n` is low, the configuration register is all zeros. That configuration makes each cell AND node 0 with itself and selects node 0 for both outputs, so both `pout` bits equal X.
- R2: On a rising clock edge with `cfg_valid` high, `cfg_word` is captured, and it governs `pout` from then on. `cfg_ready` is always 1.
- R3: On a rising edge with `cfg_valid` low, the held configuration does not change, whatever `cfg_word` carries.
- R4: The node space is numbered as follows. Node 0 is X (`pin[0]`) and node 1 is Y (`pin[1]`). Nodes 2 and 3 are cells 0 and 1, which form block 0. Nodes 4 and 5 are cells 2 and 3, which form block 1.
- R5: The 3-bit function code gives a op b as follows: 0 is AND, 1 is OR, 2 is XOR, 3 is NAND and 4 is NOR.
- R6: Function codes 5, 6 and 7 make the cell output a constant 0.
- R7: Each cell operand may name any node below the cell's own node. Both operands may name the same node.
- R8: An operand reference that is equal to or above the cell's own node index reads as 0. So do references 6 and 7.
- R9: Each output select picks node 0 to 5. A select of 6 or 7 drives 0.
- R10: `pout` follows changes on `pin` in the same cycle, with no clock edge in between.
- R11: The configuration word is laid out as follows. Cell k occupies bits [9k+8:9k]: operand a at [9k+8:9k+6], operand b at [9k+5:9k+3] and function at [9k+2:9k]. The select for `pout[0]` is at [38:36] and the select for `pout[1]` is at [41:39].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the configuration register |
| cfg_valid | input | 1 | Configuration word present |
| cfg_ready | output | 1 | Always 1; the load port never stalls |
| cfg_word | input | 42 | Configuration word (R11 layout) |
| pin | input | 2 | Primary inputs: bit 0 is X, bit 1 is Y |
| pout | output | 2 | Fabric outputs chosen by the output selects |

## Verification
The fabric is first tried with the half-adder configuration across all four input pairs. A wrong field position or wrong node numbering shows up there at once. Sweeps that change one item at a time come next: each function code on fixed operands, self-pairing of a node, references at and above a cell's own node, and out-of-range output selects. These separate decode faults from routing faults. Several hundred random words then run through every input pair, which exercises chains of cells feeding cells. A load attempted with `cfg_valid` low, followed by a fresh input sweep, shows whether the held configuration was disturbed.

// File: rtl/fab_pkg.sv
package fab_pkg;
  localparam int REF_W  = 3;
  localparam int FUNC_W = 3;

  typedef enum logic [FUNC_W-1:0] {
    FN_AND  = 3'd0,
    FN_OR   = 3'd1,
    FN_XOR  = 3'd2,
    FN_NAND = 3'd3,
    FN_NOR  = 3'd4
  } fn_e;

  typedef struct packed {
    logic [REF_W-1:0]  src_a;
    logic [REF_W-1:0]  src_b;
    logic [FUNC_W-1:0] fn;
  } cell_cfg_t;

  localparam int CELL_W = $bits(cell_cfg_t);
endpackage

// File: rtl/fab_cfg_reg.sv
module fab_cfg_reg #(
  parameter int CFG_W = 42
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] d,
  output logic [CFG_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end

  AST_CFG_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (q == $past(d))); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(q)); // R3
endmodule

// File: rtl/fab_node_sel.sv
module fab_node_sel #(
  parameter int N_VIS = 2,
  parameter int REF_W = 3
) (
  input  logic [N_VIS-1:0] nodes,
  input  logic [REF_W-1:0] sel,
  output logic             y
);
  always_comb begin
    y = 1'b0;
    for (int i = 0; i < N_VIS; i++) begin
      if (sel == REF_W'(i)) y = nodes[i];
    end
  end
endmodule

// File: rtl/fab_cell.sv
module fab_cell
  import fab_pkg::*;
(
  input  logic              a,
  input  logic              b,
  input  logic [FUNC_W-1:0] fn,
  output logic              y
);
  always_comb begin
    case (fn)
      FN_AND:  y = a & b;
      FN_OR:   y = a | b;
      FN_XOR:  y = a ^ b;
      FN_NAND: y = ~(a & b);
      FN_NOR:  y = ~(a | b);
      default: y = 1'b0;
    endcase
  end
endmodule

// File: rtl/fab_array.sv
module fab_array
  import fab_pkg::*;
#(
  parameter int N_IN          = 2,
  parameter int N_BLK         = 2,
  parameter int CELLS_PER_BLK = 2,
  parameter int N_OUT         = 2
) (
  input  logic                                             clk,
  input  logic                                             rst_n,
  input  logic                                             cfg_valid,
  output logic                                             cfg_ready,
  input  logic [N_BLK*CELLS_PER_BLK*CELL_W+N_OUT*REF_W-1:0] cfg_word,
  input  logic [N_IN-1:0]                                  pin,
  output logic [N_OUT-1:0]                                 pout
);
  localparam int N_CELL = N_BLK * CELLS_PER_BLK;
  localparam int N_NODE = N_IN + N_CELL;
  localparam int SEL_LO = N_CELL * CELL_W;
  localparam int CFG_W  = SEL_LO + N_OUT * REF_W;

  logic [CFG_W-1:0] cfg_q;

  assign cfg_ready = 1'b1;

  fab_cfg_reg #(.CFG_W(CFG_W)) u_cfg (
    .clk  (clk),
    .rst_n(rst_n),
    .load (cfg_valid),
    .d    (cfg_word),
    .q    (cfg_q)
  );

  for (genvar k = 0; k < N_CELL; k++) begin : g_cell
    logic [N_IN+k-1:0] visible;
    cell_cfg_t         cc;
    logic              opa, opb, y;

    if (k == 0) begin : g_first
      assign visible = pin;
    end else begin : g_next
      assign visible = {g_cell[k-1].y, g_cell[k-1].visible};
    end

    assign cc = cfg_q[k*CELL_W +: CELL_W];

    fab_node_sel #(.N_VIS(N_IN+k), .REF_W(REF_W)) u_sel_a (
      .nodes(visible), .sel(cc.src_a), .y(opa));
    fab_node_sel #(.N_VIS(N_IN+k), .REF_W(REF_W)) u_sel_b (
      .nodes(visible), .sel(cc.src_b), .y(opb));
    fab_cell u_cell (.a(opa), .b(opb), .fn(cc.fn), .y(y));

    AST_FWD_ONLY_A: assert property (@(posedge clk) disable iff (!rst_n)
      (cc.src_a >= REF_W'(N_IN+k)) |-> (opa == 1'b0)); // R8
    AST_FWD_ONLY_B: assert property (@(posedge clk) disable iff (!rst_n)
      (cc.src_b >= REF_W'(N_IN+k)) |-> (opb == 1'b0)); // R8
    AST_DEAD_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (cc.fn >= 3'd5) |-> (y == 1'b0)); // R6
  end

  logic [N_NODE-1:0] all_nodes;
  assign all_nodes = {g_cell[N_CELL-1].y, g_cell[N_CELL-1].visible};

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    logic [REF_W-1:0] osel;
    assign osel = cfg_q[SEL_LO + j*REF_W +: REF_W];

    fab_node_sel #(.N_VIS(N_NODE), .REF_W(REF_W)) u_osel (
      .nodes(all_nodes), .sel(osel), .y(pout[j]));

    AST_OUT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (osel >= REF_W'(N_NODE)) |-> (pout[j] == 1'b0)); // R9
    AST_OUT_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
      (osel < REF_W'(N_IN)) |-> (pout[j] == pin[osel[0]])); // R4
  end
endmodule

// File: tb/sim_fab_array.sv
`timescale 1ns/1ps
module sim_fab_array;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [41:0] cfg_word = '0;
  logic [1:0]  pin = '0;
  logic [1:0]  pout;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [41:0] model_cfg = '0;

  always #2.5 clk = ~clk;

  fab_array u0 (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_word(cfg_word), .pin(pin), .pout(pout));

  function automatic logic [8:0] cw(int a, int b, int f);
    return {3'(a), 3'(b), 3'(f)};
  endfunction

  function automatic logic [41:0] mk(logic [8:0] c0, logic [8:0] c1,
                                     logic [8:0] c2, logic [8:0] c3, int s0, int s1);
    return {3'(s1), 3'(s0), c3, c2, c1, c0};
  endfunction

  function automatic logic [1:0] model(logic [41:0] c, logic [1:0] p);
    int nd[8];
    logic [1:0] r;
    for (int i = 0; i < 8; i++) nd[i] = 0;
    nd[0] = int'(p[0]);
    nd[1] = int'(p[1]);
    for (int k = 0; k < 4; k++) begin
      int a = int'(c[9*k+6 +: 3]);
      int b = int'(c[9*k+3 +: 3]);
      int f = int'(c[9*k +: 3]);
      int va = (a < k + 2) ? nd[a] : 0;
      int vb = (b < k + 2) ? nd[b] : 0;
      case (f)
        0: nd[k+2] = va & vb;
        1: nd[k+2] = va | vb;
        2: nd[k+2] = va ^ vb;
        3: nd[k+2] = 1 - (va & vb);
        4: nd[k+2] = 1 - (va | vb);
        default: nd[k+2] = 0;
      endcase
    end
    for (int j = 0; j < 2; j++) begin
      int s = int'(c[36 + 3*j +: 3]);
      r[j] = (s < 6) ? nd[s][0] : 1'b0;
    end
    return r;
  endfunction

  task automatic check(string req, logic [1:0] exp_v);
    checks++;
    if (pout !== exp_v) begin
      failures++;
      $display("FAIL %s cfg=%h pin=%b pout=%b expected=%b", req, model_cfg, pin, pout, exp_v);
    end
  endtask

  task automatic load(logic [41:0] w);
    @(negedge clk);
    cfg_valid = 1'b1;
    cfg_word  = w;
    @(negedge clk);
    cfg_valid = 1'b0;
    cfg_word  = ~w;
    model_cfg = w;
  endtask

  // one input pair per cycle, compared against the model after settling
  task automatic sweep(string req);
    for (int v = 0; v < 4; v++) begin
      @(negedge clk);
      pin = 2'(v);
      #1;
      check(req, model(model_cfg, pin));
    end
  endtask

  initial begin
    // R1: reset state, outputs mirror X
    pin = 2'b01;
    repeat (3) @(negedge clk);
    #1; checks++; if (cfg_ready !== 1'b1) begin failures++; $display("FAIL R2 cfg_ready=%b expected=1", cfg_ready); end
    check("R1", 2'b11);
    pin = 2'b10; #1; check("R1", 2'b00);
    @(negedge clk); rst_n = 1'b1;

    // R11 / R2: half adder, pout[0]=carry node3, pout[1]=sum node2
    load(mk(cw(1,0,2), cw(0,1,0), cw(0,0,0), cw(0,0,0), 3, 2));
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); pin = 2'(v); #1;
      check("R11", {pin[0] ^ pin[1], pin[0] & pin[1]});
    end

    // R3: word presented without valid is ignored
    @(negedge clk); cfg_word = 42'h3FF_FFFF_FFFF; cfg_valid = 1'b0;
    @(negedge clk);
    sweep("R3");

    // R10: output follows pin without a clock edge
    @(negedge clk); pin = 2'b11; #0.5; check("R10", 2'b01);
    pin = 2'b01; #0.5; check("R10", 2'b10);

    // R5: each function code on X,Y
    for (int f = 0; f < 5; f++) begin
      load(mk(cw(0,1,f), 0, 0, 0, 2, 2));
      sweep("R5");
    end
    // R6: dead codes
    for (int f = 5; f < 8; f++) begin
      load(mk(cw(0,1,f), cw(1,1,1), 0, 0, 2, 3));
      sweep("R6");
    end
    // R4: node numbering, each cell passes through a distinct source
    load(mk(cw(0,0,1), cw(1,1,1), cw(2,2,3), cw(3,3,3), 4, 5));
    sweep("R4");
    load(mk(cw(0,0,1), cw(1,1,1), cw(2,2,3), cw(3,3,3), 2, 3));
    sweep("R4");
    // R7: same node both operands, chain through earlier cells
    load(mk(cw(0,0,2), cw(1,1,4), cw(3,2,1), cw(4,1,2), 4, 5));
    sweep("R7");
    // R8: self and forward references read 0
    load(mk(cw(2,0,3), cw(5,1,1), cw(4,4,3), cw(7,6,4), 3, 5));
    sweep("R8");
    // R9: selects 6 and 7 drive 0, select 5 drives cell 3
    load(mk(cw(0,0,1), 0, 0, cw(1,1,1), 6, 7));
    sweep("R9");
    load(mk(cw(0,0,1), 0, 0, cw(1,1,4), 5, 7));
    sweep("R9");

    // R7 / R8: random configurations
    for (int n = 0; n < 300; n++) begin
      load({10'($urandom), $urandom});
      sweep("R7_R8_random");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule